// File: doc/BRIEF.md
# Three-Level Thread Issue Arbiter

This block picks, in every cycle, at most one of four hardware threads to send an instruction to the issue stage. Each thread presents a request flag and a two-bit priority code that software programs. Among the requesting threads, the arbiter finds the highest effective level present and rotates fairly among the threads at that level. A waiting thread that keeps losing grants is raised in effective level, so a thread programmed medium or low cannot starve.

The output is a valid/ready handshake. `grant_vld` with a one-hot `grant` offers a thread. The issue stage accepts it by raising `issue_ready` in the same cycle. A grant counts as issued only when both are high. While `issue_ready` is low the offer is held back: the rotation pointer and every wait counter keep their values, so the same thread is offered again as long as the requests do not change. The offer is combinational from the current requests and the internal state.

Top module: `thread_issue_arbiter`

## Requirements
- R1: After reset the rotation pointer points at thread 0 and all wait counters are zero. With no request, `grant` is 0 and `grant_vld` is 0. With all threads requesting at one level, thread 0 is offered first.
- R2: `grant` is either zero or one-hot. It only names a thread whose `req_vld` bit is set. `grant_vld` is high exactly when `grant` is nonzero, and that is exactly when any thread requests.
- R3: The priority code of thread i is `req_prio[2*i+1:2*i]`: 2'b00 means low, 2'b01 means medium, and 2'b10 or 2'b11 mean high. The offer always goes to a thread at the highest effective level among the requesters.
- R4: Among requesters at the winning level, the first thread at or after the rotation pointer is chosen, wrapping from thread 3 to thread 0. On a taken grant the pointer moves to the thread after the granted one.
- R5: In a cycle where `issue_ready` is low, no state changes: the pointer and the wait counters hold. With unchanged requests, the same thread is offered in the next cycle.
- R6: A requesting thread's wait counter rises by one for each taken grant that goes to another thread, up to 2*TIMEOUT. At TIMEOUT lost grants (default 8) the effective level rises by one step, and at 2*TIMEOUT it rises by a second step, capped at high. So a medium thread becomes high after TIMEOUT lost grants, and a low thread becomes medium after TIMEOUT and high after 2*TIMEOUT.
- R7: A thread's wait counter returns to zero when its grant is taken or when its request drops. Its effective level then falls back to its programmed level.
- R8: A thread that keeps requesting is taken after no more than 2*TIMEOUT + NUM_THR - 1 taken grants to other threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NUM_THR | Request flag per thread |
| req_prio | input | 2*NUM_THR | Programmed priority code per thread, two bits each |
| issue_ready | input | 1 | Issue stage accepts the current offer |
| grant | output | NUM_THR | One-hot thread offered this cycle |
| grant_vld | output | 1 | An offer is present |

## Verification
The assertions check on every cycle that the grant is one-hot or zero and lies within the requests, and that `grant_vld` matches the request set. They also check that a stalled offer is repeated when the requests stay the same, and that no continuously requesting thread loses more grants than the starvation bound allows. The directed scenarios are what show the cycle-exact behaviour: the rotation order after reset, the precedence of the three levels, the exact lost-grant counts at which medium and low threads are promoted, the counter clearing on a dropped request, and the pointer staying put during back-pressure.

// File: rtl/tia_pkg.sv
package tia_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } tia_lvl_e;

  // Software code to level: 00 low, 01 medium, 1x high.
  function automatic tia_lvl_e tia_decode(input logic [1:0] code);
    if (code[1])      return LVL_HIGH;
    else if (code[0]) return LVL_MED;
    else              return LVL_LOW;
  endfunction

endpackage

// File: rtl/tia_wait_tracker.sv
module tia_wait_tracker
  import tia_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  tia_lvl_e prog_lvl,
  input  logic     take_any,
  input  logic     take_me,
  output tia_lvl_e eff_lvl
);
  localparam int SAT = 2 * TIMEOUT;
  localparam int CW  = $clog2(SAT + 1);

  logic [CW-1:0] wait_cnt;
  logic [1:0]    steps;
  logic [2:0]    raised;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!req || take_me) begin
      wait_cnt <= '0;
    end else if (take_any && (wait_cnt < CW'(SAT))) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_comb begin
    steps  = {1'b0, (wait_cnt >= CW'(TIMEOUT))} + {1'b0, (wait_cnt >= CW'(SAT))};
    raised = {1'b0, prog_lvl} + {1'b0, steps};
    if (raised >= 3'd2) eff_lvl = LVL_HIGH;
    else                eff_lvl = tia_lvl_e'(raised[1:0]);
  end

endmodule

// File: rtl/tia_rr_pick.sv
module tia_rr_pick #(
  parameter int NUM_THR = 4,
  localparam int PW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic [NUM_THR-1:0] cand,
  input  logic [PW-1:0]      ptr,
  output logic [NUM_THR-1:0] pick
);
  always_comb begin
    logic found;
    int   idx;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_THR; i++) begin
      idx = (int'(ptr) + i) % NUM_THR;
      if (!found && cand[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/thread_issue_arbiter.sv
module thread_issue_arbiter
  import tia_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int TIMEOUT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_THR-1:0]   req_vld,
  input  logic [2*NUM_THR-1:0] req_prio,
  input  logic                 issue_ready,
  output logic [NUM_THR-1:0]   grant,
  output logic                 grant_vld
);
  localparam int PW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

  tia_lvl_e            eff [NUM_THR];
  logic [NUM_THR-1:0]  take_vec;
  logic                take_any;
  logic [NUM_THR-1:0]  cand;
  tia_lvl_e            top_lvl;
  logic [PW-1:0]       rr_ptr;
  logic [PW-1:0]       next_ptr;

  assign take_any = grant_vld & issue_ready;
  assign take_vec = grant & {NUM_THR{issue_ready}};

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    tia_wait_tracker #(.TIMEOUT(TIMEOUT)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_vld[t]),
      .prog_lvl (tia_decode(req_prio[2*t +: 2])),
      .take_any (take_any),
      .take_me  (take_vec[t]),
      .eff_lvl  (eff[t])
    );
  end

  always_comb begin
    top_lvl = LVL_LOW;
    for (int t = 0; t < NUM_THR; t++) begin
      if (req_vld[t] && (eff[t] > top_lvl)) top_lvl = eff[t];
    end
    for (int t = 0; t < NUM_THR; t++) begin
      cand[t] = req_vld[t] && (eff[t] == top_lvl);
    end
  end

  tia_rr_pick #(.NUM_THR(NUM_THR)) u_pick (
    .cand (cand),
    .ptr  (rr_ptr),
    .pick (grant)
  );

  assign grant_vld = |grant;

  always_comb begin
    next_ptr = rr_ptr;
    for (int t = 0; t < NUM_THR; t++) begin
      if (grant[t]) next_ptr = (t == NUM_THR - 1) ? '0 : PW'(t + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rr_ptr <= '0;
    else if (take_any) rr_ptr <= next_ptr;
  end

endmodule

// File: rtl/thread_issue_arbiter_chk.sv
module thread_issue_arbiter_chk #(
  parameter int NUM_THR = 4,
  parameter int TIMEOUT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_THR-1:0]   req_vld,
  input logic [2*NUM_THR-1:0] req_prio,
  input logic                 issue_ready,
  input logic [NUM_THR-1:0]   grant,
  input logic                 grant_vld
);
  localparam int BOUND = 2 * TIMEOUT + NUM_THR - 1;

  int lost [NUM_THR];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_THR; t++) begin
      if (!rst_n || !req_vld[t] || (grant[t] && issue_ready)) lost[t] <= 0;
      else if (grant_vld && issue_ready)                     lost[t] <= lost[t] + 1;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_vld) == '0);

  // R2
  grant_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (|req_vld));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !issue_ready) |=>
      (!$stable(req_vld) || !$stable(req_prio) || $stable(grant)));

  // R8
  for (genvar t = 0; t < NUM_THR; t++) begin : g_bound
    starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lost[t] <= BOUND);
  end

endmodule

bind thread_issue_arbiter thread_issue_arbiter_chk #(
  .NUM_THR (NUM_THR),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .req_prio    (req_prio),
  .issue_ready (issue_ready),
  .grant       (grant),
  .grant_vld   (grant_vld)
);

// File: tb/thread_issue_arbiter_tb.sv
module thread_issue_arbiter_tb;
  localparam int NT    = 4;
  localparam int TO    = 8;
  localparam int BOUND = 2 * TO + NT - 1;

  localparam logic [1:0] PL = 2'b00, PM = 2'b01, PH = 2'b10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] req_vld;
  logic [2*NT-1:0] req_prio;
  logic          issue_ready;
  logic [NT-1:0] grant;
  logic          grant_vld;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  thread_issue_arbiter #(.NUM_THR(NT), .TIMEOUT(TO)) u_dut (
    .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_prio (req_prio),
    .issue_ready (issue_ready), .grant (grant), .grant_vld (grant_vld)
  );

  task automatic check(input bit ok, input string tag, input logic [NT-1:0] act,
                       input logic [NT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Sample the combinational offer away from the edge, then let one edge pass.
  task automatic expect_grant(input logic [NT-1:0] exp, input string tag);
    #1;
    check((grant === exp) && (grant_vld === (|exp)), tag, grant, exp);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; req_vld = '0; req_prio = '0; issue_ready = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    expect_grant(4'b0000, "R1 idle after reset");
    req_vld = 4'b1111; req_prio = {PM, PM, PM, PM}; issue_ready = 1'b0;
    expect_grant(4'b0001, "R1 thread0 first");
  endtask

  task automatic t_rotate;
    do_reset();
    req_vld = 4'b1111; req_prio = {PH, PH, PH, PH};
    expect_grant(4'b0001, "R4 rr t0");
    expect_grant(4'b0010, "R4 rr t1");
    expect_grant(4'b0100, "R4 rr t2");
    expect_grant(4'b1000, "R4 rr t3");
    expect_grant(4'b0001, "R4 rr wrap");
  endtask

  task automatic t_levels;
    do_reset();
    issue_ready = 1'b0;
    req_vld = 4'b0111; req_prio = {PL, PH, PM, PL};
    expect_grant(4'b0100, "R3 high wins");
    req_vld = 4'b0011;
    expect_grant(4'b0010, "R3 medium over low");
    req_vld = 4'b1001; req_prio = {2'b11, PL, PL, PM};
    expect_grant(4'b1000, "R3 code 11 is high");
  endtask

  task automatic t_stall;
    do_reset();
    req_vld = 4'b1111; req_prio = {PH, PH, PH, PH}; issue_ready = 1'b0;
    expect_grant(4'b0001, "R5 stalled c1");
    expect_grant(4'b0001, "R5 stalled c2");
    expect_grant(4'b0001, "R5 stalled c3");
    issue_ready = 1'b1;
    expect_grant(4'b0001, "R5 taken after stall");
    expect_grant(4'b0010, "R5 pointer moved once");
  endtask

  task automatic t_promote_med;
    do_reset();
    req_vld = 4'b0011; req_prio = {PL, PL, PH, PM};
    for (int i = 0; i < TO; i++) expect_grant(4'b0010, "R6 medium waits");
    expect_grant(4'b0001, "R6 medium promoted");
    for (int i = 0; i < TO; i++) expect_grant(4'b0010, "R7 counter cleared on take");
    expect_grant(4'b0001, "R7 promoted again");
  endtask

  task automatic t_promote_low;
    do_reset();
    req_vld = 4'b0011; req_prio = {PL, PL, PH, PL};
    for (int i = 0; i < 2 * TO; i++) expect_grant(4'b0010, "R6 low waits");
    expect_grant(4'b0001, "R6 low promoted to high");
  endtask

  task automatic t_low_vs_med;
    do_reset();
    // thread0 low, thread1 medium, thread2 high
    req_vld = 4'b0111; req_prio = {PL, PH, PM, PL};
    for (int i = 0; i < TO; i++) expect_grant(4'b0100, "R6 both wait");
    // thread1 now high, thread0 medium; pointer at 3 -> wraps to thread1 before thread2
    expect_grant(4'b0010, "R6 medium promoted first");
    expect_grant(4'b0100, "R6 high again");
  endtask

  task automatic t_drop;
    do_reset();
    req_vld = 4'b0011; req_prio = {PL, PL, PH, PM};
    for (int i = 0; i < 5; i++) expect_grant(4'b0010, "R7 partial wait");
    req_vld = 4'b0010;
    expect_grant(4'b0010, "R7 request dropped");
    req_vld = 4'b0011;
    for (int i = 0; i < TO; i++) expect_grant(4'b0010, "R7 full wait after drop");
    expect_grant(4'b0001, "R7 promoted after fresh wait");
  endtask

  task automatic t_random;
    logic [15:0] lfsr = 16'hACE1;
    int lost [NT];
    do_reset();
    for (int t = 0; t < NT; t++) lost[t] = 0;
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_vld     = lfsr[3:0] | 4'b1001;
      req_prio    = {lfsr[5:4], PL, lfsr[9:8], PL};
      issue_ready = lfsr[11] | lfsr[12];
      #1;
      check($onehot0(grant) && ((grant & ~req_vld) == '0) && (grant_vld == (|req_vld)),
            "R2 one-hot within requests", grant, req_vld);
      for (int t = 0; t < NT; t++) begin
        if (!req_vld[t] || (grant[t] && issue_ready)) lost[t] = 0;
        else if (grant_vld && issue_ready)           lost[t]++;
        if (lost[t] > BOUND) check(1'b0, "R8 starvation bound", 4'(lost[t]), 4'(BOUND));
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(1'b1, "R8 random run", '0, '0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rotate();
    t_levels();
    t_stall();
    t_promote_med();
    t_promote_low();
    t_low_vs_med();
    t_drop();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule